// File: doc/BRIEF.md
# OSD Layer Priority Pixel Mixer

This block merges three on-screen-display layers (cursor, graphics and text) into a single pixel. Every layer delivers a valid flag and a 4-bit color code. On each pixel-clock enable the mixer picks the winning layer and registers four results: the chosen color code, a tag that names the source, an overlay-switch signal (`ys_o`) and a translucency signal (`ym_o`).

An 8-bit control word steers the choice. It holds an enable for each layer and the priority order of graphics against text. It also decides whether color 0 counts as see-through, whether color 15 is shown as translucent, whether the overlay switch is held off during translucent output, and whether a background color fills pixels where no layer is visible. Palette lookup, tile fetch and shape rendering take place upstream of this block.

Top module: `osd_pixel_mixer`

## Requirements
- R1: A layer can supply a pixel only when its valid flag is high and its enable bit is 1. The enable bits are: `ctrl_i[0]` for the cursor, `ctrl_i[1]` for graphics and `ctrl_i[2]` for text.
- R2: A visible cursor pixel wins over graphics and over text.
- R3: When `ctrl_i[3]`=0, graphics wins over text. When `ctrl_i[3]`=1, text wins over graphics.
- R4: When `ctrl_i[4]`=0, color code 0 in any layer is invisible and the next lower-priority layer shows through. When `ctrl_i[4]`=1, color 0 is drawn like any other color.
- R5: When `ctrl_i[5]`=0, a selected layer pixel with color code 15 drives `ym_o`=1. When `ctrl_i[5]`=1, that pixel is drawn opaque and `ym_o`=0. `ym_o` is 0 for every other color code.
- R6: When `ctrl_i[6]`=1 and `ym_o` is 1 with a nonzero color, `ys_o` is 0. When `ctrl_i[6]`=0, `ys_o` is 1 for every output pixel.
- R7: If no layer is visible and `ctrl_i[7]`=1, the output is `bg_col_i` with tag 1, `ys_o`=1 and `ym_o`=0. If no layer is visible and `ctrl_i[7]`=0, the output is color 0 with tag 0, `ys_o`=0 and `ym_o`=0.
- R8: The source tag uses these codes: 0 = nothing, 1 = background, 2 = cursor, 3 = graphics, 4 = text.
- R9: All outputs are registered. They update together on the rising edge where `pix_en_i`=1, and they hold their values while `pix_en_i`=0.
- R10: During and after reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pix_en_i | input | 1 | Pixel-clock enable |
| ctrl_i | input | 8 | Control word (bit meanings given in R1 to R7) |
| cur_vld_i | input | 1 | Cursor pixel valid |
| cur_col_i | input | 4 | Cursor color code |
| gfx_vld_i | input | 1 | Graphics pixel valid |
| gfx_col_i | input | 4 | Graphics color code |
| txt_vld_i | input | 1 | Text pixel valid |
| txt_col_i | input | 4 | Text color code |
| bg_col_i | input | 4 | Background color code |
| col_o | output | 4 | Selected color code |
| src_o | output | 3 | Source tag (codes given in R8) |
| ys_o | output | 1 | Overlay switch |
| ym_o | output | 1 | Translucency signal |

## Verification
Two effects can fall on the same pixel: the translucent handling of color 15 and the hold-off of the overlay switch. The bench drives a graphics pixel of color 15 with the hold-off bit both set and clear, and with the translucency bit both set and clear. It then checks that `ys_o` drops only when `ym_o` is high. Transparency and priority can also act on the same pixel. A cursor or graphics pixel of color 0 is placed over a lower layer, and the bench checks that the lower layer wins only while color 0 is see-through.

// File: rtl/osd_pixel_mixer.sv
module osd_pixel_mixer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pix_en_i,
  input  logic [7:0]    ctrl_i,
  input  logic          cur_vld_i,
  input  logic [CW-1:0] cur_col_i,
  input  logic          gfx_vld_i,
  input  logic [CW-1:0] gfx_col_i,
  input  logic          txt_vld_i,
  input  logic [CW-1:0] txt_col_i,
  input  logic [CW-1:0] bg_col_i,
  output logic [CW-1:0] col_o,
  output logic [2:0]    src_o,
  output logic          ys_o,
  output logic          ym_o
);
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};
  localparam logic [2:0] S_NONE = 3'd0, S_BG = 3'd1, S_CUR = 3'd2,
                         S_GFX = 3'd3, S_TXT = 3'd4;

  logic cur_ok, gfx_ok, txt_ok;
  logic [CW-1:0] col_n;
  logic [2:0] src_n;
  logic ym_n, ys_n;

  assign cur_ok = ctrl_i[0] & cur_vld_i & (ctrl_i[4] | (cur_col_i != '0));
  assign gfx_ok = ctrl_i[1] & gfx_vld_i & (ctrl_i[4] | (gfx_col_i != '0));
  assign txt_ok = ctrl_i[2] & txt_vld_i & (ctrl_i[4] | (txt_col_i != '0));

  always_comb begin
    col_n = '0;
    src_n = S_NONE;
    if (cur_ok) begin
      col_n = cur_col_i; src_n = S_CUR;
    end else if (ctrl_i[3] && txt_ok) begin
      col_n = txt_col_i; src_n = S_TXT;
    end else if (gfx_ok) begin
      col_n = gfx_col_i; src_n = S_GFX;
    end else if (txt_ok) begin
      col_n = txt_col_i; src_n = S_TXT;
    end else if (ctrl_i[7]) begin
      col_n = bg_col_i; src_n = S_BG;
    end
  end

  assign ym_n = (src_n > S_BG) && (col_n == CMAX) && !ctrl_i[5];
  assign ys_n = (src_n != S_NONE) && !(ctrl_i[6] && ym_n && (col_n != '0));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_o <= '0;
      src_o <= S_NONE;
      ys_o  <= 1'b0;
      ym_o  <= 1'b0;
    end else if (pix_en_i) begin
      col_o <= col_n;
      src_o <= src_n;
      ys_o  <= ys_n;
      ym_o  <= ym_n;
    end
  end

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_en_i |=> $stable({col_o, src_o, ys_o, ym_o}));
  p_cursor_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_en_i && !ctrl_i[0]) |=> (src_o != S_CUR));
  p_ym_only_15_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ym_o |-> (col_o == CMAX) && (src_o > S_BG));
  p_ys_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_en_i && ctrl_i[6]) |=> !(ys_o && ym_o));
  p_quiet_none_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (src_o == S_NONE) |-> (!ys_o && !ym_o && col_o == '0));
  p_tag_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    src_o <= S_TXT);
endmodule

// File: tb/osd_pixel_mixer_test.sv
module osd_pixel_mixer_test;
  logic clk = 0, rst_n = 0, pix_en = 0;
  logic [7:0] ctrl = 0;
  logic cv = 0, gv = 0, tv = 0;
  logic [3:0] cc = 0, gc = 0, tc = 0, bg = 0;
  logic [3:0] col; logic [2:0] src; logic ys, ym;
  int errors = 0, checks = 0;

  always #10 clk = ~clk;

  osd_pixel_mixer uut (.clk(clk), .rst_n(rst_n), .pix_en_i(pix_en), .ctrl_i(ctrl),
    .cur_vld_i(cv), .cur_col_i(cc), .gfx_vld_i(gv), .gfx_col_i(gc),
    .txt_vld_i(tv), .txt_col_i(tc), .bg_col_i(bg),
    .col_o(col), .src_o(src), .ys_o(ys), .ym_o(ym));

  // ctrl, cv,cc, gv,gc, tv,tc, bg | col, src, ys, ym
  localparam int NV = 13;
  localparam logic [35:0] VEC [NV] = '{
    {8'h07, 1'b1,4'd3, 1'b1,4'd5, 1'b1,4'd6, 4'd0, 4'd3, 3'd2, 1'b1,1'b0}, // R2
    {8'h06, 1'b1,4'd3, 1'b1,4'd5, 1'b1,4'd6, 4'd0, 4'd5, 3'd3, 1'b1,1'b0}, // R1 R3
    {8'h0E, 1'b1,4'd3, 1'b1,4'd5, 1'b1,4'd6, 4'd0, 4'd6, 3'd4, 1'b1,1'b0}, // R3
    {8'h07, 1'b1,4'd0, 1'b1,4'd0, 1'b1,4'd9, 4'd0, 4'd9, 3'd4, 1'b1,1'b0}, // R4
    {8'h17, 1'b1,4'd0, 1'b1,4'd0, 1'b1,4'd9, 4'd0, 4'd0, 3'd2, 1'b1,1'b0}, // R4
    {8'h07, 1'b0,4'd1, 1'b1,4'd15,1'b1,4'd2, 4'd0, 4'd15,3'd3, 1'b1,1'b1}, // R5
    {8'h27, 1'b0,4'd1, 1'b1,4'd15,1'b1,4'd2, 4'd0, 4'd15,3'd3, 1'b1,1'b0}, // R5
    {8'h47, 1'b0,4'd1, 1'b1,4'd15,1'b1,4'd2, 4'd0, 4'd15,3'd3, 1'b0,1'b1}, // R6
    {8'h67, 1'b0,4'd1, 1'b1,4'd15,1'b1,4'd2, 4'd0, 4'd15,3'd3, 1'b1,1'b0}, // R6
    {8'h87, 1'b0,4'd1, 1'b0,4'd2, 1'b0,4'd3, 4'd10,4'd10,3'd1, 1'b1,1'b0}, // R7 R8
    {8'h07, 1'b0,4'd1, 1'b0,4'd2, 1'b0,4'd3, 4'd10,4'd0, 3'd0, 1'b0,1'b0}, // R7
    {8'h80, 1'b1,4'd1, 1'b1,4'd2, 1'b1,4'd3, 4'd12,4'd12,3'd1, 1'b1,1'b0}, // R1
    {8'h06, 1'b1,4'd3, 1'b0,4'd5, 1'b1,4'd6, 4'd0, 4'd6, 3'd4, 1'b1,1'b0}  // R1
  };

  task automatic drive(input logic [26:0] v);
    {ctrl, cv, cc, gv, gc, tv, tc, bg} = v;
  endtask

  task automatic check(input string req, input logic [8:0] exp);
    checks++;
    if ({col, src, ys, ym} !== exp) begin
      errors++;
      $display("FAIL %s: got col=%0d src=%0d ys=%0b ym=%0b, expected col=%0d src=%0d ys=%0b ym=%0b",
        req, col, src, ys, ym, exp[8:5], exp[4:2], exp[1], exp[0]);
    end
  endtask

  task automatic step(input logic [26:0] v);
    @(negedge clk); drive(v); pix_en = 1;
    @(negedge clk); pix_en = 0;
  endtask

  initial begin
    #1000000;
    errors++; checks++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    drive(VEC[0][35:9]); pix_en = 1;
    repeat (3) @(negedge clk);
    check("R10 in reset", 9'd0);
    rst_n = 1; pix_en = 0;
    @(negedge clk);
    check("R10 after reset", 9'd0);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][35:9]);
      check($sformatf("vector %0d (R1-R8 table)", i), VEC[i][8:0]);
    end

    // R9: hold while the enable is low
    step(VEC[0][35:9]);
    @(negedge clk); drive(VEC[2][35:9]);
    repeat (3) @(negedge clk);
    check("R9 hold", {4'd3, 3'd2, 1'b1, 1'b0});
    // R9: update takes effect one edge after the enable
    @(negedge clk); pix_en = 1;
    @(negedge clk); pix_en = 0;
    check("R9 update", {4'd6, 3'd4, 1'b1, 1'b0});

    // R6: the hold-off bit does not affect opaque colors
    step({8'h46, 1'b0,4'd0, 1'b1,4'd7, 1'b0,4'd0, 4'd0});
    check("R6 opaque ys", {4'd7, 3'd3, 1'b1, 1'b0});

    // R5: cursor color 15 is translucent while text is below it
    step({8'h0F, 1'b1,4'd15, 1'b1,4'd4, 1'b1,4'd8, 4'd0});
    check("R5 R2 cursor 15", {4'd15, 3'd2, 1'b1, 1'b1});

    // R10: reset in the middle of operation
    @(negedge clk); rst_n = 0;
    @(negedge clk);
    check("R10 mid reset", 9'd0);
    rst_n = 1;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule